// File: doc/BRIEF.md
# Gate-Synchronous Sample Strobe with PI Voltage Update

This block belongs to the digital loop of a current-mode switching regulator that uses constant on-time or constant off-time modulation. It issues the conversion strobe for the output-voltage ADC. The strobe is tied to one edge of the high-side gate drive, so every sample is taken at the same point of the switching cycle. A one-bit mode input picks that edge. If the chosen edge does not arrive within a programmable number of clock cycles, for example during a long on-time while the regulator slews up, the block issues uniformly spaced fallback strobes. The voltage loop therefore keeps updating until gate edges return.

When the ADC reports a result, the block forms the error as reference minus sample and runs one proportional-integral step. It registers a new DAC code and marks it with a one-cycle valid pulse. Both gains are unsigned fixed-point values with four fractional bits. The integrator and the output are both clamped to the DAC code range. Integration is suspended while the previous output sat on a rail and the new error would push further into that rail. The ADC, the DAC and the analog comparator path are outside the block.

Top module: `evs_sample_pi`

## Requirements
- R1: With `on_time_mode_i` = 0, a rising edge of `gate_hi_i` makes `sample_stb_o` high for exactly the next cycle. A falling edge produces no strobe of its own.
- R2: With `on_time_mode_i` = 1, a falling edge of `gate_hi_i` makes `sample_stb_o` high for the next cycle. A rising edge produces no strobe of its own.
- R3: If no selected edge arrives, `sample_stb_o` rises `timeout_i` cycles after the previous strobe, or after the first cycle out of reset, and it repeats every `timeout_i` cycles. `timeout_i` must be at least 1, and the value 1 gives a strobe on every cycle.
- R4: Every strobe, whether from an edge or from the fallback, restarts the interval count. An edge that arrives in the same cycle as a timeout gives one single strobe.
- R5: The error is `vref_i - adc_data_i`, taken together with the gains in the cycle where `adc_ready_i` is high. Without `adc_ready_i`, `dac_valid_o` stays low and `dac_code_o` holds its value.
- R6: For each accepted sample, I += ki·e, u = I + kp·e and code = floor(u/16), clamped to [0, 2^DAC_W−1]. The gains carry 4 fractional bits, so 16 means 1.0. `dac_valid_o` pulses, with the new code, exactly two cycles after `adc_ready_i`. Samples may arrive on back-to-back cycles.
- R7: The integrator I stays within [0, (2^DAC_W−1)·16].
- R8: If the last output was clamped high and e > 0, or clamped low and e < 0, I is left unchanged for that sample. Clamped high means u/16 > 2^DAC_W−1. Clamped low means u < 0.
- R9: During reset, `sample_stb_o` and `dac_valid_o` are 0, `dac_code_o` is 0 and the integrator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| on_time_mode_i | input | 1 | 0: strobe on gate rising edge, 1: strobe on gate falling edge |
| gate_hi_i | input | 1 | High-side gate drive, synchronous to clk_i |
| timeout_i | input | CNT_W | Fallback interval in clock cycles |
| sample_stb_o | output | 1 | One-cycle ADC conversion strobe |
| adc_ready_i | input | 1 | ADC result valid |
| adc_data_i | input | ADC_W | ADC sample of the output voltage |
| vref_i | input | ADC_W | Voltage reference code |
| kp_i | input | G_W | Proportional gain, 4 fractional bits |
| ki_i | input | G_W | Integral gain, 4 fractional bits |
| dac_code_o | output | DAC_W | Registered controller output code |
| dac_valid_o | output | 1 | One-cycle pulse marking a new code |

## Verification
The gate-edge path and the timeout path can both request a strobe in the same cycle. The bench provokes this by raising the gate in exactly the cycle in which its own interval count reaches the limit, and repeats that several times. It expects one single-cycle strobe and the next fallback a full interval later. On the controller side, an accepted sample and a finished update overlap whenever ready pulses come on consecutive cycles. The bench runs saturation sequences whose visible code after the gains are zeroed shows whether integration was held or clamped.

// File: rtl/evs_pkg.sv
package evs_pkg;
    localparam logic MODE_OFF_TIME = 1'b0;  // rising gate edge samples
    localparam logic MODE_ON_TIME  = 1'b1;  // falling gate edge samples

    localparam int DEF_CNT_W = 16;
    localparam int DEF_ADC_W = 10;
    localparam int DEF_DAC_W = 10;
    localparam int DEF_G_W   = 8;
    localparam int DEF_FRAC  = 4;
endpackage

// File: rtl/evs_strobe_gen.sv
module evs_strobe_gen
    import evs_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_i,
    input  logic             gate_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic             gate_prev;
        logic             strobe;
        logic [CNT_W-1:0] cnt;
    } stb_state_t;

    stb_state_t s_d, s_q;
    logic       edge_hit;
    logic       time_hit;
    logic [CNT_W:0] cnt_next;

    always_comb begin
        s_d      = s_q;
        cnt_next = {1'b0, s_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (mode_i == MODE_ON_TIME) begin
            edge_hit = s_q.gate_prev & ~gate_i;
        end else begin
            edge_hit = ~s_q.gate_prev & gate_i;
        end
        time_hit    = (cnt_next >= {1'b0, limit_i});
        s_d.gate_prev = gate_i;
        s_d.strobe    = edge_hit | time_hit;
        s_d.cnt       = s_d.strobe ? '0 : cnt_next[CNT_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe_o = s_q.strobe;

    // R1: selected rising edge in off-time mode yields a strobe next cycle
    assert_rise_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_OFF_TIME && $rose(gate_i)) |=> strobe_o);

    // R2: selected falling edge in on-time mode yields a strobe next cycle
    assert_fall_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_ON_TIME && $fell(gate_i)) |=> strobe_o);

    // R4: a strobe always restarts the interval count
    assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |-> (s_q.cnt == '0));
endmodule

// File: rtl/evs_pi_core.sv
module evs_pi_core
    import evs_pkg::*;
#(
    parameter int ADC_W = DEF_ADC_W,
    parameter int DAC_W = DEF_DAC_W,
    parameter int G_W   = DEF_G_W,
    parameter int FRAC  = DEF_FRAC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ready_i,
    input  logic [ADC_W-1:0] sample_i,
    input  logic [ADC_W-1:0] ref_i,
    input  logic [G_W-1:0]   kp_i,
    input  logic [G_W-1:0]   ki_i,
    output logic [DAC_W-1:0] code_o,
    output logic             valid_o
);
    localparam int ERR_W   = ADC_W + 1;
    localparam int PROD_W  = ERR_W + G_W + 1;
    localparam int INT_W   = DAC_W + FRAC + 1;
    localparam int SUM_W   = ((PROD_W > INT_W) ? PROD_W : INT_W) + 2;
    localparam int OUT_MAX = (2 ** DAC_W) - 1;
    localparam int INT_MAX = OUT_MAX * (2 ** FRAC);

    typedef struct packed {
        logic                     a_vld;
        logic signed [ERR_W-1:0]  err;
        logic signed [PROD_W-1:0] p_term;
        logic signed [PROD_W-1:0] i_term;
        logic signed [INT_W-1:0]  integ;
        logic                     sat_hi;
        logic                     sat_lo;
        logic [DAC_W-1:0]         code;
        logic                     vld;
    } pi_state_t;

    pi_state_t s_d, s_q;

    logic signed [ERR_W-1:0]  err_c;
    logic signed [G_W:0]      kp_s;
    logic signed [G_W:0]      ki_s;
    logic                     hold_c;
    logic signed [SUM_W-1:0]  inc_c;
    logic signed [SUM_W-1:0]  integ_sum;
    logic signed [SUM_W-1:0]  integ_clip;
    logic signed [SUM_W-1:0]  u_c;
    logic signed [SUM_W-1:0]  u_sh;

    always_comb begin
        s_d = s_q;

        // stage A: error and gain products
        err_c = $signed({1'b0, ref_i}) - $signed({1'b0, sample_i});
        kp_s  = $signed({1'b0, kp_i});
        ki_s  = $signed({1'b0, ki_i});
        s_d.a_vld = ready_i;
        if (ready_i) begin
            s_d.err    = err_c;
            s_d.p_term = PROD_W'(err_c) * PROD_W'(kp_s);
            s_d.i_term = PROD_W'(err_c) * PROD_W'(ki_s);
        end

        // stage B: integrate, sum, clamp
        hold_c = (s_q.sat_hi && (s_q.err > 0)) || (s_q.sat_lo && (s_q.err < 0));
        inc_c  = '0;
        if (!hold_c) begin
            inc_c = SUM_W'(s_q.i_term);
        end
        integ_sum = SUM_W'(s_q.integ) + inc_c;
        if (integ_sum < 0) begin
            integ_clip = '0;
        end else if (integ_sum > SUM_W'(INT_MAX)) begin
            integ_clip = SUM_W'(INT_MAX);
        end else begin
            integ_clip = integ_sum;
        end
        u_c  = integ_clip + SUM_W'(s_q.p_term);
        u_sh = u_c >>> FRAC;

        s_d.vld = s_q.a_vld;
        if (s_q.a_vld) begin
            s_d.integ = INT_W'(integ_clip);
            if (u_sh > SUM_W'(OUT_MAX)) begin
                s_d.code   = DAC_W'(OUT_MAX);
                s_d.sat_hi = 1'b1;
                s_d.sat_lo = 1'b0;
            end else if (u_sh < 0) begin
                s_d.code   = '0;
                s_d.sat_hi = 1'b0;
                s_d.sat_lo = 1'b1;
            end else begin
                s_d.code   = u_sh[DAC_W-1:0];
                s_d.sat_hi = 1'b0;
                s_d.sat_lo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o  = s_q.code;
    assign valid_o = s_q.vld;

    // R5: without a new result the code holds
    assert_code_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(code_o));

    // R6: a ready pulse produces a valid pulse two cycles later
    assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_i |=> ##1 valid_o);

    // R7: integrator stays inside its range
    assert_integ_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.integ >= 0) && (s_q.integ <= INT_W'(INT_MAX)));

    // R8: integration held while pushing into a rail
    assert_windup_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.a_vld && s_q.sat_hi && (s_q.err > 0)) |=> $stable(s_q.integ));
endmodule

// File: rtl/evs_sample_pi.sv
module evs_sample_pi
    import evs_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int ADC_W = DEF_ADC_W,
    parameter int DAC_W = DEF_DAC_W,
    parameter int G_W   = DEF_G_W,
    parameter int FRAC  = DEF_FRAC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             on_time_mode_i,
    input  logic             gate_hi_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             sample_stb_o,
    input  logic             adc_ready_i,
    input  logic [ADC_W-1:0] adc_data_i,
    input  logic [ADC_W-1:0] vref_i,
    input  logic [G_W-1:0]   kp_i,
    input  logic [G_W-1:0]   ki_i,
    output logic [DAC_W-1:0] dac_code_o,
    output logic             dac_valid_o
);
    evs_strobe_gen #(
        .CNT_W (CNT_W)
    ) i_strobe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (on_time_mode_i),
        .gate_i   (gate_hi_i),
        .limit_i  (timeout_i),
        .strobe_o (sample_stb_o)
    );

    evs_pi_core #(
        .ADC_W (ADC_W),
        .DAC_W (DAC_W),
        .G_W   (G_W),
        .FRAC  (FRAC)
    ) i_pi (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ready_i  (adc_ready_i),
        .sample_i (adc_data_i),
        .ref_i    (vref_i),
        .kp_i     (kp_i),
        .ki_i     (ki_i),
        .code_o   (dac_code_o),
        .valid_o  (dac_valid_o)
    );

    // R9: outputs quiet in the first cycle after reset
    assert_reset_quiet_R9: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!sample_stb_o && !dac_valid_o && dac_code_o == '0));
endmodule

// File: tb/test_evs_sample_pi.sv
`timescale 1ns/1ps
module test_evs_sample_pi;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        gate = 1'b0;
    logic [15:0] lim = 16'd40;
    logic        stb;
    logic        rdy = 1'b0;
    logic [9:0]  adc = '0;
    logic [9:0]  vref = 10'd512;
    logic [7:0]  kp = 8'd16;
    logic [7:0]  ki = 8'd2;
    logic [9:0]  code;
    logic        vld;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string pi_tag = "R6";

    // reference model state
    bit gprev = 0;
    int cnt = 0;
    int integ = 0;
    bit sat_hi = 0, sat_lo = 0;
    bit pend_v = 0;
    int pend_code = 0;
    bit exp_v = 0;
    int exp_code = 0;

    always #2.5 clk = ~clk;

    evs_sample_pi i_evs_sample_pi (
        .clk_i(clk), .rst_ni(rst_n), .on_time_mode_i(mode), .gate_hi_i(gate),
        .timeout_i(lim), .sample_stb_o(stb), .adc_ready_i(rdy), .adc_data_i(adc),
        .vref_i(vref), .kp_i(kp), .ki_i(ki), .dac_code_o(code), .dac_valid_o(vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic int pi_step(input int smp);
        int e, u, us, lo, hi;
        e  = int'(vref) - smp;
        hi = 1023 * 16;
        if (!((sat_hi && e > 0) || (sat_lo && e < 0))) integ = integ + int'(ki) * e;
        if (integ < 0) integ = 0;
        if (integ > hi) integ = hi;
        u  = integ + int'(kp) * e;
        us = u >>> 4;
        lo = 0;
        if (us > 1023) begin sat_hi = 1; sat_lo = 0; return 1023; end
        if (us < 0)    begin sat_hi = 0; sat_lo = 1; return lo; end
        sat_hi = 0; sat_lo = 0;
        return us;
    endfunction

    task automatic cyc(input bit g, input bit r, input int smp);
        bit e_edge, e_to, e_stb;
        string stag;
        @(negedge clk);
        gate = g; rdy = r; adc = smp[9:0];
        e_edge = mode ? (gprev && !g) : (!gprev && g);
        e_to   = (cnt + 1 >= int'(lim));
        e_stb  = e_edge || e_to;
        gprev  = g;
        cnt    = e_stb ? 0 : cnt + 1;
        if (e_edge && e_to) stag = "R4";
        else if (e_edge)    stag = mode ? "R2" : "R1";
        else if (e_to)      stag = "R3";
        else                stag = mode ? "R2" : "R1";
        exp_v = pend_v;
        if (pend_v) exp_code = pend_code;
        pend_v = r;
        if (r) pend_code = pi_step(smp);
        @(posedge clk); #1;
        check(stb === e_stb, stag, int'(stb), int'(e_stb));
        check(vld === exp_v, exp_v ? pi_tag : "R5", int'(vld), int'(exp_v));
        check(code === exp_code[9:0], exp_v ? pi_tag : "R5", int'(code), exp_code);
    endtask

    task automatic samp(input int smp, input int idle);
        cyc(gate, 1'b1, smp);
        for (int k = 0; k < idle; k++) cyc(gate, 1'b0, smp);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(stb === 1'b0, "R9", int'(stb), 0);
        check(vld === 1'b0, "R9", int'(vld), 0);
        check(code === 10'd0, "R9", int'(code), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(stb === 1'b0 && vld === 1'b0, "R9", int'(stb), 0);
        cnt = 1;

        // R1: off-time mode, gate period 20, timeout 40
        for (int c = 0; c < 200; c++)
            cyc((c % 20) < 8, (c % 7) == 3, 400 + (c % 50) * 3);
        // R2: on-time mode
        mode = 1'b1;
        for (int c = 0; c < 200; c++)
            cyc((c % 20) < 12, (c % 5) == 1, 600 - (c % 40) * 4);
        // R3: long on-time, fallback strobes
        mode = 1'b0; lim = 16'd25;
        for (int c = 0; c < 150; c++) cyc(1'b1, (c % 9) == 0, 500);
        // R4: edge in the timeout cycle
        lim = 16'd20;
        for (int rep = 0; rep < 6; rep++) begin
            cyc(1'b0, 1'b0, 0);
            while (cnt + 1 < int'(lim)) cyc(1'b0, 1'b0, 0);
            cyc(1'b1, 1'b0, 0);
            cyc(1'b1, 1'b0, 0);
        end
        // R6: back-to-back samples
        lim = 16'd1000; pi_tag = "R6";
        for (int c = 0; c < 12; c++) cyc(gate, 1'b1, 480 + c * 7);
        for (int k = 0; k < 3; k++) cyc(gate, 1'b0, 0);
        // R8: saturate high through kp, integration held
        pi_tag = "R8";
        kp = 8'd0; ki = 8'd0; vref = 10'd500; samp(500, 0); samp(500, 2);
        vref = 10'd600; kp = 8'd255; ki = 8'd8;
        for (int c = 0; c < 6; c++) samp(500, 1);
        kp = 8'd0; ki = 8'd0; samp(600, 3);
        vref = 10'd0; kp = 8'd255; ki = 8'd8;
        for (int c = 0; c < 5; c++) samp(900, 1);
        kp = 8'd16; ki = 8'd16; vref = 10'd300; samp(200, 3);
        // R7: integrator clamp at top
        pi_tag = "R7";
        vref = 10'd1023; kp = 8'd0; ki = 8'd255;
        for (int c = 0; c < 4; c++) samp(0, 1);
        ki = 8'd16; samp(1024 - 1, 0); samp(1023, 0); vref = 10'd1022; samp(1023, 3);
        // R3: timeout of one cycle
        lim = 16'd1;
        for (int c = 0; c < 10; c++) cyc(1'b0, 1'b0, 0);
        lim = 16'd3;
        for (int c = 0; c < 12; c++) cyc(c == 5, 1'b0, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule